// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data between two peripherals and a simple memory bus. Each channel has its own start address, transfer count and command word, and a status word. A peripheral raises its request line while it can accept or supply a unit. The controller then runs one memory access of 1, 2 or 4 bytes and answers with a one-cycle acknowledge. After each unit the address steps by the unit size and the count steps down by one. The count is loaded as the number of units minus one.

Software programs the address, then the count, then writes the command word, and that write arms the channel. When the last unit completes, the channel halts and raises its interrupt. The interrupt level is taken from a command field. Errors also halt the channel and raise the interrupt. These are a misaligned start address, an address that rolls over past the top, and a memory bus error.

Two register views reach the same channels. The native view has a 32-bit count and a separate status word. The narrow view has a 16-bit count and returns status at its command location. Reading the narrow view's address register acknowledges the interrupt. The two channels share one memory port. The port goes to the channel with its priority bit set, and to channel 0 when both or neither have that bit.

Top module: `dma2_ctrl`

## Requirements
- R1: After reset, every address, count, command and status register reads zero, irq is low and mem_req is low.
- R2: Register index = {view, channel, offset}. The narrow view (view 0) has offset 0 = address, offset 1 = count and offset 2 = status on read or command on write. The native view (view 1) has offset 0 = address, 1 = 32-bit count, 2 = command and 3 = status. A narrow count write loads wdata[15:0] and clears the upper count bits. A narrow count read returns the low 16 count bits.
- R3: A command write with bit 0 and bit 15 both set arms the channel when the address is aligned. Arming sets status bit 0 and clears status bits 1, 3, 4, 5 and 6. Any other command write clears status bit 0 and starts no transfer.
- R4: An armed channel with count value C performs exactly C+1 units, each acknowledged on per_ack. The count register ends at all ones.
- R5: Command bit 8 selects 4-byte units (mem_size 2). Otherwise bit 1 selects 2-byte units (mem_size 1). Otherwise units are single bytes (mem_size 0). The address steps by the unit size after each unit.
- R6: With command bit 2 set, units are memory writes (mem_we=1) carrying per_wdata. With bit 2 clear, units are memory reads, and per_rdata equals mem_rdata while per_ack is high.
- R7: After the last unit the channel clears status bit 0 and sets halt (bit 3) and interrupt (bit 1), so that status reads 0x0A. irq for the channel goes high, and its irq_level field equals command bits 6:4 plus 3.
- R8: Reading narrow-view offset 0 of a channel clears that channel's interrupt. Native-view reads leave it pending.
- R9: When both channels request, the channel whose command bit 3 is set and whose partner's is clear wins. Otherwise channel 0 wins. At most one per_ack bit is high.
- R10: Arming with an address that is not a multiple of the unit size sets status bits 5, 3 and 1 (status 0x2A) and starts no memory access.
- R11: An address step that carries past the top of the address space sets status bit 6. The transfer continues from address 0.
- R12: mem_err together with mem_ready sets status bits 4, 3 and 1 (status 0x1A), disarms the channel, gives no per_ack for that unit and starts no further unit.
- R13: Status bit 2 is set while the channel's memory access is outstanding. mem_req and mem_addr stay stable until mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 4 | Register index {view, channel, offset} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 2 | Peripheral unit request per channel |
| per_ack | output | 2 | Unit completed, per channel |
| per_wdata | input | 32 | Peripheral data toward memory |
| per_rdata | output | 32 | Memory data toward peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Unit size code 0/1/2 = 1/2/4 bytes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Access ended with bus error |
| irq | output | 2 | Interrupt pending per channel |
| irq_level | output | 6 | Interrupt level per channel, 3 bits each |

## Verification
The bench goes after off-by-one count handling. A design that treats the count as the exact length would produce one unit too few, and the scoreboard would see the missing access. It arms transfers at misaligned addresses and just below the top of the address space, so a design that ignored alignment would issue a stray access and one that missed the carry would leave the wrap flag clear. It raises both requests in the same cycle with and without the priority bit, so a reversed tie rule shows up as accesses in the wrong order. It also checks which reads clear the interrupt, so a design that cleared on any read would drop irq early.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } unit_sz_e;

    // command word layout (bit positions are decoded by software)
    typedef struct packed {
        logic       go;        // 15
        logic [5:0] spare_hi;  // 14:9
        logic       quad;      // 8  four-byte units
        logic       spare_lo;  // 7
        logic [2:0] lvl;       // 6:4 interrupt level minus 3
        logic       pri;       // 3
        logic       to_mem;    // 2  peripheral -> memory
        logic       half;      // 1  two-byte units
        logic       en;        // 0
    } cmd_t;

    // status word layout, bit 0 first from the right
    typedef struct packed {
        logic wrap;   // 6
        logic align;  // 5
        logic berr;   // 4
        logic halt;   // 3
        logic acc;    // 2
        logic intr;   // 1
        logic armed;  // 0
    } stat_t;

    localparam int LVL_BIAS = 3;

    function automatic unit_sz_e unit_size(cmd_t c);
        if (c.quad)      return SZ_WORD;
        else if (c.half) return SZ_HALF;
        return SZ_BYTE;
    endfunction

    function automatic logic [2:0] unit_step(unit_sz_e s);
        return 3'(1) << s;
    endfunction

    function automatic logic misaligned(unit_sz_e s, logic [1:0] lo);
        case (s)
            SZ_HALF: return lo[0];
            SZ_WORD: return |lo;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 32,
    parameter int NCNT_W  = 16,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              cnt_narrow,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_intr,
    input  logic              busy,
    input  logic              unit_done,
    input  logic              unit_err,
    input  logic              req_in,
    output logic [ADDR_W-1:0] ch_addr,
    output logic [CNT_W-1:0]  ch_count,
    output cmd_t              ch_cmd,
    output stat_t             ch_stat,
    output unit_sz_e          ch_size,
    output logic              ch_we,
    output logic              want
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    cmd_t              cmd_q;
    logic armed_q, intr_q, halt_q, berr_q, align_q, wrap_q;

    cmd_t     new_cmd;
    unit_sz_e new_sz;
    logic     arm_req, bad_align;
    logic [ADDR_W:0] next_addr;

    always_comb begin
        new_cmd   = cmd_t'(wdata[15:0]);
        new_sz    = unit_size(new_cmd);
        arm_req   = wr_cmd && new_cmd.en && new_cmd.go;
        bad_align = misaligned(new_sz, addr_q[1:0]);
        next_addr = {1'b0, addr_q} + (ADDR_W+1)'(unit_step(unit_size(cmd_q)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            cmd_q   <= '0;
            armed_q <= 1'b0;
            intr_q  <= 1'b0;
            halt_q  <= 1'b0;
            berr_q  <= 1'b0;
            align_q <= 1'b0;
            wrap_q  <= 1'b0;
        end else begin
            if (clr_intr)
                intr_q <= 1'b0;
            if (wr_addr)
                addr_q <= wdata[ADDR_W-1:0];
            if (wr_cnt)
                cnt_q <= cnt_narrow ? CNT_W'(wdata[NCNT_W-1:0]) : wdata[CNT_W-1:0];
            if (wr_cmd) begin
                cmd_q  <= new_cmd;
                if (arm_req) begin
                    berr_q <= 1'b0;
                    wrap_q <= 1'b0;
                    if (bad_align) begin
                        armed_q <= 1'b0;
                        halt_q  <= 1'b1;
                        align_q <= 1'b1;
                        intr_q  <= 1'b1;
                    end else begin
                        armed_q <= 1'b1;
                        halt_q  <= 1'b0;
                        align_q <= 1'b0;
                        intr_q  <= 1'b0;
                    end
                end else begin
                    armed_q <= 1'b0;
                end
            end else if (unit_done && armed_q) begin
                if (unit_err) begin
                    berr_q  <= 1'b1;
                    halt_q  <= 1'b1;
                    armed_q <= 1'b0;
                    intr_q  <= 1'b1;
                end else begin
                    addr_q <= next_addr[ADDR_W-1:0];
                    if (next_addr[ADDR_W])
                        wrap_q <= 1'b1;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == '0) begin
                        armed_q <= 1'b0;
                        halt_q  <= 1'b1;
                        intr_q  <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        ch_addr  = addr_q;
        ch_count = cnt_q;
        ch_cmd   = cmd_q;
        ch_size  = unit_size(cmd_q);
        ch_we    = cmd_q.to_mem;
        want     = armed_q && req_in;
        ch_stat  = '{wrap: wrap_q, align: align_q, berr: berr_q, halt: halt_q,
                     acc: busy, intr: intr_q, armed: armed_q};
    end

    AST_ARMED_NEVER_HALTED: assert property (@(posedge clk) disable iff (rst)
        !(armed_q && halt_q)); // R7
    AST_INTR_WITH_HALT: assert property (@(posedge clk) disable iff (rst)
        $rose(intr_q) |-> halt_q); // R7
    AST_ALIGN_NOT_ARMED: assert property (@(posedge clk) disable iff (rst)
        align_q |-> !armed_q); // R10

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] want,
    input  logic [NCH-1:0] pri,
    output logic [NCH-1:0] grant
);

    logic [NCH-1:0] hot;

    always_comb begin
        hot   = want & pri;
        grant = '0;
        if (|hot) begin
            for (int i = NCH - 1; i >= 0; i--)
                if (hot[i]) grant = NCH'(1) << i;
        end else begin
            for (int i = NCH - 1; i >= 0; i--)
                if (want[i]) grant = NCH'(1) << i;
        end
    end

endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
    import dma2_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NCH-1:0]               grant,
    input  logic [NCH-1:0][ADDR_W-1:0]   ch_addr,
    input  unit_sz_e [NCH-1:0]           ch_size,
    input  logic [NCH-1:0]               ch_we,
    input  logic                         mem_ready,
    input  logic                         mem_err,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [1:0]                   mem_size,
    output logic [NCH-1:0]               unit_done,
    output logic                         unit_err,
    output logic [NCH-1:0]               busy,
    output logic [NCH-1:0]               per_ack
);

    localparam int OW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef enum logic {ST_IDLE, ST_XFER} eng_st_e;

    eng_st_e        st_q;
    logic [OW-1:0]  owner_q;
    logic [OW-1:0]  pick;

    always_comb begin
        pick = '0;
        for (int i = 0; i < NCH; i++)
            if (grant[i]) pick = OW'(i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            owner_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (|grant) begin
                    st_q    <= ST_XFER;
                    owner_q <= pick;
                end
                ST_XFER: if (mem_ready) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = (st_q == ST_XFER);
        mem_addr = ch_addr[owner_q];
        mem_size = ch_size[owner_q];
        mem_we   = ch_we[owner_q];
        unit_err = mem_err;
        for (int i = 0; i < NCH; i++) begin
            busy[i]      = mem_req && (owner_q == OW'(i));
            unit_done[i] = busy[i] && mem_ready;
            per_ack[i]   = unit_done[i] && !mem_err;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R9
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(unit_done)); // R9

endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
    import dma2_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int NCNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [$clog2(NCH)+2:0]      reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [NCH-1:0]              per_req,
    output logic [NCH-1:0]              per_ack,
    input  logic [DATA_W-1:0]           per_wdata,
    output logic [DATA_W-1:0]           per_rdata,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [1:0]                  mem_size,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic                        mem_ready,
    input  logic                        mem_err,
    output logic [NCH-1:0]              irq,
    output logic [3*NCH-1:0]            irq_level
);

    localparam int CH_W  = $clog2(NCH);
    localparam int IDX_W = CH_W + 3;

    localparam logic [1:0] OFF_ADDR = 2'd0;
    localparam logic [1:0] OFF_CNT  = 2'd1;
    localparam logic [1:0] OFF_CMD  = 2'd2;
    localparam logic [1:0] OFF_STAT = 2'd3;

    logic              native;
    logic [CH_W-1:0]   sel_ch;
    logic [1:0]        off;

    logic [NCH-1:0][ADDR_W-1:0] ch_addr;
    logic [NCH-1:0][CNT_W-1:0]  ch_count;
    cmd_t     [NCH-1:0]         ch_cmd;
    stat_t    [NCH-1:0]         ch_stat;
    unit_sz_e [NCH-1:0]         ch_size;
    logic [NCH-1:0]             ch_we, want, pri, grant;
    logic [NCH-1:0]             busy, unit_done;
    logic                       unit_err;

    assign native = reg_addr[IDX_W-1];
    assign sel_ch = reg_addr[IDX_W-2:2];
    assign off    = reg_addr[1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit, w_addr, w_cnt, w_cmd, rd_clr;
        assign hit    = (sel_ch == CH_W'(c));
        assign w_addr = reg_wr && hit && (off == OFF_ADDR);
        assign w_cnt  = reg_wr && hit && (off == OFF_CNT);
        assign w_cmd  = reg_wr && hit && (off == OFF_CMD);
        assign rd_clr = reg_rd && hit && !native && (off == OFF_ADDR);

        dma2_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .NCNT_W (NCNT_W),
            .DATA_W (DATA_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_addr    (w_addr),
            .wr_cnt     (w_cnt),
            .cnt_narrow (!native),
            .wr_cmd     (w_cmd),
            .wdata      (reg_wdata),
            .clr_intr   (rd_clr),
            .busy       (busy[c]),
            .unit_done  (unit_done[c]),
            .unit_err   (unit_err),
            .req_in     (per_req[c]),
            .ch_addr    (ch_addr[c]),
            .ch_count   (ch_count[c]),
            .ch_cmd     (ch_cmd[c]),
            .ch_stat    (ch_stat[c]),
            .ch_size    (ch_size[c]),
            .ch_we      (ch_we[c]),
            .want       (want[c])
        );

        assign pri[c]            = ch_cmd[c].pri;
        assign irq[c]            = ch_stat[c].intr;
        assign irq_level[3*c +: 3] = ch_cmd[c].lvl + 3'(LVL_BIAS);
    end

    dma2_arb #(.NCH(NCH)) u_arb (
        .want  (want),
        .pri   (pri),
        .grant (grant)
    );

    dma2_engine #(.NCH(NCH), .ADDR_W(ADDR_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .ch_addr   (ch_addr),
        .ch_size   (ch_size),
        .ch_we     (ch_we),
        .mem_ready (mem_ready),
        .mem_err   (mem_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .unit_done (unit_done),
        .unit_err  (unit_err),
        .busy      (busy),
        .per_ack   (per_ack)
    );

    assign mem_wdata = per_wdata;
    assign per_rdata = mem_rdata;

    always_comb begin
        reg_rdata = '0;
        case ({native, off})
            {1'b0, OFF_ADDR}: reg_rdata = DATA_W'(ch_addr[sel_ch]);
            {1'b0, OFF_CNT }: reg_rdata = DATA_W'(ch_count[sel_ch][NCNT_W-1:0]);
            {1'b0, OFF_CMD }: reg_rdata = DATA_W'(ch_stat[sel_ch]);
            {1'b1, OFF_ADDR}: reg_rdata = DATA_W'(ch_addr[sel_ch]);
            {1'b1, OFF_CNT }: reg_rdata = DATA_W'(ch_count[sel_ch]);
            {1'b1, OFF_CMD }: reg_rdata = DATA_W'(ch_cmd[sel_ch]);
            {1'b1, OFF_STAT}: reg_rdata = DATA_W'(ch_stat[sel_ch]);
            default:          reg_rdata = '0;
        endcase
    end

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        $onehot0(per_ack)); // R9
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R13
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        |per_ack |-> mem_req && mem_ready && !mem_err); // R12

endmodule

// File: tb/tb_dma2_ctrl.sv
module tb_dma2_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [1:0]  per_req = '0, per_ack;
    logic [31:0] per_wdata = 32'hC0DE_F00D, per_rdata;
    logic        mem_req, mem_we, mem_ready, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic [1:0]  irq;
    logic [5:0]  irq_level;
    logic        stall = 1'b0, err_inj = 1'b0;

    int n_chk = 0, n_err = 0;
    int acks0 = 0, acks1 = 0;

    always #2.5 clk = ~clk;

    assign mem_ready = mem_req && !stall;
    assign mem_err   = mem_ready && err_inj;
    assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

    dma2_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
        .irq(irq), .irq_level(irq_level)
    );

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        we;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic push_units(logic [31:0] a, int n, logic [1:0] sz, logic we, string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{addr: a, size: sz, we: we, tag: tag});
            a = a + (32'd1 << sz);
        end
    endtask

    // monitor: pops one expected unit per completed memory access
    always @(negedge clk) begin
        if (!rst && mem_req && mem_ready) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected access", mem_addr, 32'hxxxx_xxxx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " addr"}, mem_addr, e.addr);
                check({e.tag, " size"}, 32'(mem_size), 32'(e.size));
                check({e.tag, " R6 dir"}, 32'(mem_we), 32'(e.we));
                if (mem_we)
                    check("R6 wdata", mem_wdata, per_wdata);
                else if (!mem_err)
                    check("R6 rdata", per_rdata, mem_addr ^ 32'hA5A5_0000);
                if (!mem_err)
                    check("R4 ack", 32'($countones(per_ack)), 32'd1);
                else
                    check("R12 no ack", 32'(per_ack), 32'd0);
            end
            if (per_ack[0]) acks0++;
            if (per_ack[1]) acks1++;
        end
    end

    task automatic wr(logic [3:0] idx, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = idx;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(int c);
        int n = 0;
        while (!irq[c] && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) check("irq timeout", 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    // index: {view, ch, off}; native = 8 + 4*ch, narrow = 4*ch
    localparam logic [31:0] ARM = 32'h8001, HALF = 32'h2, TOMEM = 32'h4,
                            PRI = 32'h8, QUAD = 32'h100;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check("watchdog", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(4'd8, d);  check("R1 addr0", d, 32'h0);
        rd(4'd11, d); check("R1 stat0", d, 32'h0);
        rd(4'd14, d); check("R1 cmd1", d, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 mem_req", 32'(mem_req), 32'h0);

        // R2 register views
        wr(4'd12, 32'h1234_5678);
        rd(4'd12, d); check("R2 native addr1", d, 32'h1234_5678);
        wr(4'd1, 32'hABCD_1234);
        rd(4'd9, d);  check("R2 narrow count zero-ext", d, 32'h0000_1234);
        wr(4'd9, 32'h0003_0007);
        rd(4'd1, d);  check("R2 narrow count read", d, 32'h0000_0007);

        per_req = 2'b11;
        // byte read transfer, ch0, 4 units, level field 2
        push_units(32'h100, 4, 2'd0, 1'b0, "R5 byte");
        wr(4'd8, 32'h100); wr(4'd9, 32'd3); wr(4'd10, ARM | 32'h20);
        wait_irq(0);
        check("R7 irq_level", 32'(irq_level[2:0]), 32'd5);
        rd(4'd11, d); check("R7 status done", d, 32'h0A);
        rd(4'd9, d);  check("R4 count end", d, 32'hFFFF_FFFF);
        rd(4'd8, d);  check("R5 byte step", d, 32'h104);
        check("R4 ack count", 32'(acks0), 32'd4);
        check("R8 native read keeps irq", 32'(irq[0]), 32'd1);
        rd(4'd2, d);  check("R8 narrow cmd reads status", d, 32'h0A);
        rd(4'd0, d);  check("R8 narrow addr value", d, 32'h104);
        check("R8 irq cleared", 32'(irq[0]), 32'd0);

        // four-byte write transfer, ch1
        push_units(32'h2000, 3, 2'd2, 1'b1, "R5 quad");
        wr(4'd12, 32'h2000); wr(4'd13, 32'd2); wr(4'd14, ARM | QUAD | TOMEM);
        wait_irq(1);
        rd(4'd15, d); check("R7 ch1 status", d, 32'h0A);
        rd(4'd12, d); check("R5 quad step", d, 32'h200C);
        check("R4 ch1 acks", 32'(acks1), 32'd3);
        rd(4'd4, d);
        check("R8 ch1 irq cleared", 32'(irq[1]), 32'd0);

        // two-byte units with a stalled bus
        stall = 1'b1;
        push_units(32'h300, 2, 2'd1, 1'b0, "R5 half");
        wr(4'd8, 32'h300); wr(4'd9, 32'd1); wr(4'd10, ARM | HALF);
        repeat (5) @(negedge clk);
        rd(4'd11, d); check("R13 access flag", d, 32'h05);
        check("R13 req held", 32'(mem_req), 32'd1);
        check("R13 addr held", mem_addr, 32'h300);
        stall = 1'b0;
        wait_irq(0);
        rd(4'd8, d); check("R5 half step", d, 32'h304);
        rd(4'd0, d);

        // priority: ch1 flagged wins
        per_req = 2'b00;
        push_units(32'h500, 2, 2'd0, 1'b0, "R9 pri ch1");
        push_units(32'h400, 2, 2'd0, 1'b0, "R9 pri ch0");
        wr(4'd8, 32'h400);  wr(4'd9, 32'd1);  wr(4'd10, ARM);
        wr(4'd12, 32'h500); wr(4'd13, 32'd1); wr(4'd14, ARM | PRI);
        @(negedge clk); per_req = 2'b11;
        wait_irq(0); wait_irq(1);
        rd(4'd0, d); rd(4'd4, d);
        check("R9 pri queue drained", 32'(exp_q.size()), 32'd0);

        // priority tie: channel 0 wins
        per_req = 2'b00;
        push_units(32'h600, 2, 2'd0, 1'b0, "R9 tie ch0");
        push_units(32'h700, 2, 2'd0, 1'b0, "R9 tie ch1");
        wr(4'd8, 32'h600);  wr(4'd9, 32'd1);  wr(4'd10, ARM | PRI);
        wr(4'd12, 32'h700); wr(4'd13, 32'd1); wr(4'd14, ARM | PRI);
        @(negedge clk); per_req = 2'b11;
        wait_irq(0); wait_irq(1);
        rd(4'd0, d); rd(4'd4, d);

        // alignment error
        wr(4'd8, 32'h801); wr(4'd9, 32'd0); wr(4'd10, ARM | HALF);
        wait_irq(0);
        rd(4'd11, d); check("R10 align status", d, 32'h2A);
        rd(4'd0, d);

        // address wrap
        push_units(32'hFFFF_FFFE, 2, 2'd1, 1'b0, "R11 wrap");
        wr(4'd8, 32'hFFFF_FFFE); wr(4'd9, 32'd1); wr(4'd10, ARM | HALF);
        wait_irq(0);
        rd(4'd11, d); check("R11 wrap status", d, 32'h4A);
        rd(4'd8, d);  check("R11 wrapped addr", d, 32'h2);
        rd(4'd0, d);

        // R3: command without start bit does not arm
        wr(4'd8, 32'h900); wr(4'd9, 32'd0); wr(4'd10, 32'h0001);
        repeat (6) @(negedge clk);
        rd(4'd11, d); check("R3 not armed", d & 32'h1, 32'h0);
        // R3: proper arm clears old error flags
        push_units(32'h900, 1, 2'd0, 1'b0, "R3 rearm");
        wr(4'd10, ARM);
        wait_irq(0);
        rd(4'd11, d); check("R3 flags cleared", d, 32'h0A);
        rd(4'd0, d);

        // bus error
        err_inj = 1'b1;
        push_units(32'hA00, 1, 2'd0, 1'b0, "R12 berr");
        wr(4'd12, 32'hA00); wr(4'd13, 32'd3); wr(4'd14, ARM);
        wait_irq(1);
        err_inj = 1'b0;
        repeat (10) @(negedge clk);
        rd(4'd15, d); check("R12 berr status", d, 32'h1A);
        check("R12 no further units", 32'(exp_q.size()), 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule